// File: doc/BRIEF.md
# RAM Segment Playback Sequencer

This block holds a table of 32-bit tuning words in on-chip RAM and plays one address segment of that table to its output, one word at a time. The output feeds a synthesizer as its frequency tuning word. Four segment descriptors are kept, one per profile. Each descriptor gives a dwell rate, two end addresses and a playback style. Two profile pins pick the descriptor that is used. The dwell rate says how many clock cycles each address is held before the sequencer moves on. Two styles are offered. The first climbs once from the lower address to the upper address and then stays on the last word. The second sweeps up and down between the two addresses without end.

Descriptors are written through a simple write port into shadow slots. A slot becomes active only when playback restarts. Playback restarts when the update strobe is pulsed or when the profile pins change value. At a restart the descriptor of the selected profile is latched and the address jumps to the lower end of the segment. The table is filled through a load port. A load starts at the upper end of the active segment and moves downward. After the lower end it wraps back to the upper end.

Top module: `segplay_top`

## Requirements
- R1: After synchronous reset `cur_addr` is 0 and every descriptor slot is zero. The active segment is therefore address 0 alone, and the address stays at 0 until a restart.
- R2: A write with `cfg_we` high stores the descriptor fields into slot `cfg_slot`. The write has no effect on playback until the next restart, even if that slot is the active one.
- R3: A cycle with `ld_start` high moves the load pointer to the upper address of the active segment. Each cycle with `ld_valid` high writes `ld_data` at the pointer and then moves the pointer one address down. Below the lower address the pointer wraps to the upper address. When `ld_start` and `ld_valid` are high together, the write goes to the upper address.
- R4: `tw_out` always equals the RAM word at `cur_addr`, in the same cycle.
- R5: With a dwell rate N of 1 or more, each address is held for exactly N clock cycles. A rate of 0 behaves as a rate of 1.
- R6: A restart happens when `upd` is high, or when `prof_sel` differs from the profile latched at the last restart. One clock edge after the restart, the descriptor of `prof_sel` is active and `cur_addr` equals its lower address.
- R7: When `cfg_bidir` = 1, the address climbs by one per dwell period up to the upper address, then falls by one per dwell period to the lower address, and repeats for as long as no restart occurs.
- R8: When `cfg_bidir` = 0, the address climbs by one per dwell period to the upper address and then holds there.
- R9: When the first address written is greater than the last, the two are swapped. The segment then runs from the smaller address to the larger one.
- R10: Outside the restart edge, `cur_addr` always lies within the active segment and changes by at most one address per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prof_sel | input | 2 | Profile select pins |
| upd | input | 1 | Update strobe; restarts playback |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_slot | input | 2 | Descriptor slot to write |
| cfg_rate | input | 16 | Dwell cycles per address |
| cfg_first | input | 10 | First segment address |
| cfg_last | input | 10 | Last segment address |
| cfg_bidir | input | 1 | 1 = continuous up/down sweep, 0 = single climb and hold |
| ld_start | input | 1 | Moves the load pointer to the upper address of the active segment |
| ld_valid | input | 1 | Writes `ld_data` at the load pointer |
| ld_data | input | 32 | Table word to write |
| tw_out | output | 32 | Tuning word at the current address |
| cur_addr | output | 10 | Current playback address |

## Verification
A restart seen at a rising edge shows up after that same edge: at the following falling edge `cur_addr` is the lower address and `tw_out` is already that address's word, since the read adds no register. From then on every address holds for N samples, and a table write is readable one edge after it is made. The bench fills its scoreboard just after the restart edge, with one expected address-and-word item per cycle built from its own model of the sweep. A monitor takes one item at each falling edge, so every comparison falls in the exact cycle the rules above give.

// File: rtl/segplay_pkg.sv
package segplay_pkg;

    localparam int SP_ADDR_W = 10;
    localparam int SP_WORD_W = 32;
    localparam int SP_RATE_W = 16;
    localparam int SP_PROF_W = 2;
    localparam int SP_NPROF  = 1 << SP_PROF_W;
    localparam int SP_DEPTH  = 1 << SP_ADDR_W;

    typedef logic [SP_ADDR_W-1:0] sp_addr_t;
    typedef logic [SP_WORD_W-1:0] sp_word_t;
    typedef logic [SP_RATE_W-1:0] sp_rate_t;
    typedef logic [SP_PROF_W-1:0] sp_prof_t;

    typedef enum logic {
        SP_ONESHOT = 1'b0,
        SP_BIDIR   = 1'b1
    } sp_mode_e;

    // Segment descriptor, always stored with lo <= hi
    typedef struct packed {
        sp_rate_t rate;
        sp_addr_t lo;
        sp_addr_t hi;
        sp_mode_e mode;
    } sp_seg_t;

    // Playback position: address and sweep direction
    typedef struct packed {
        sp_addr_t addr;
        logic     up;
    } sp_pos_t;

    function automatic sp_seg_t sp_normalize(sp_rate_t rate, sp_addr_t first,
                                             sp_addr_t last, sp_mode_e mode);
        sp_seg_t s;
        s.rate = rate;
        s.mode = mode;
        if (first > last) begin
            s.lo = last;
            s.hi = first;
        end else begin
            s.lo = first;
            s.hi = last;
        end
        return s;
    endfunction

    // Terminal count of the dwell counter; a rate of zero acts as one
    function automatic sp_rate_t sp_dwell_last(sp_rate_t rate);
        if (rate == '0)
            return '0;
        return rate - sp_rate_t'(1);
    endfunction

    function automatic sp_pos_t sp_advance(sp_pos_t cur, sp_seg_t seg);
        sp_pos_t nxt;
        nxt = cur;
        if (seg.lo == seg.hi) begin
            nxt.addr = seg.lo;
        end else if (seg.mode == SP_ONESHOT) begin
            if (cur.addr < seg.hi)
                nxt.addr = cur.addr + sp_addr_t'(1);
        end else if (cur.up) begin
            if (cur.addr < seg.hi) begin
                nxt.addr = cur.addr + sp_addr_t'(1);
            end else begin
                nxt.addr = cur.addr - sp_addr_t'(1);
                nxt.up   = 1'b0;
            end
        end else begin
            if (cur.addr > seg.lo) begin
                nxt.addr = cur.addr - sp_addr_t'(1);
            end else begin
                nxt.addr = cur.addr + sp_addr_t'(1);
                nxt.up   = 1'b1;
            end
        end
        return nxt;
    endfunction

    // Load pointer walks downward and wraps from lo back to hi
    function automatic sp_addr_t sp_load_next(sp_addr_t ptr, sp_addr_t lo, sp_addr_t hi);
        if (ptr == lo)
            return hi;
        return ptr - sp_addr_t'(1);
    endfunction

endpackage

// File: rtl/sp_cfg_bank.sv
module sp_cfg_bank
    import segplay_pkg::*;
#(
    parameter int NPROF = SP_NPROF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  sp_prof_t wr_slot,
    input  sp_seg_t  wr_seg,
    input  sp_prof_t rd_slot,
    output sp_seg_t  rd_seg
);

    sp_seg_t bank [NPROF];

    for (genvar g = 0; g < NPROF; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= '0;
            else if (we && (wr_slot == sp_prof_t'(g)))
                bank[g] <= wr_seg;
        end
    end

    assign rd_seg = bank[rd_slot];

endmodule

// File: rtl/sp_table_ram.sv
module sp_table_ram
    import segplay_pkg::*;
#(
    parameter int AW = SP_ADDR_W,
    parameter int DW = SP_WORD_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sp_loader.sv
module sp_loader
    import segplay_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ld_start,
    input  logic     ld_valid,
    input  sp_addr_t seg_lo,
    input  sp_addr_t seg_hi,
    output logic     wr_en,
    output sp_addr_t wr_addr
);

    sp_addr_t ptr;
    sp_addr_t base;

    assign base    = ld_start ? seg_hi : ptr;
    assign wr_en   = ld_valid;
    assign wr_addr = base;

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (ld_valid)
            ptr <= sp_load_next(base, seg_lo, seg_hi);
        else if (ld_start)
            ptr <= seg_hi;
    end

endmodule

// File: rtl/sp_stepper.sv
module sp_stepper
    import segplay_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  sp_addr_t start_addr,
    input  sp_seg_t  seg,
    output sp_addr_t addr,
    output logic     step
);

    sp_rate_t cnt;
    sp_rate_t last;
    logic     up;
    sp_pos_t  cur;
    sp_pos_t  nxt;

    assign last = sp_dwell_last(seg.rate);
    assign step = !restart && (cnt == last);
    assign cur  = {addr, up};
    assign nxt  = sp_advance(cur, seg);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cnt  <= '0;
            up   <= 1'b1;
        end else if (restart) begin
            addr <= start_addr;
            cnt  <= '0;
            up   <= 1'b1;
        end else if (cnt == last) begin
            cnt  <= '0;
            addr <= nxt.addr;
            up   <= nxt.up;
        end else begin
            cnt  <= cnt + sp_rate_t'(1);
        end
    end

endmodule

// File: rtl/segplay_top.sv
module segplay_top
    import segplay_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SP_PROF_W-1:0] prof_sel,
    input  logic                 upd,
    input  logic                 cfg_we,
    input  logic [SP_PROF_W-1:0] cfg_slot,
    input  logic [SP_RATE_W-1:0] cfg_rate,
    input  logic [SP_ADDR_W-1:0] cfg_first,
    input  logic [SP_ADDR_W-1:0] cfg_last,
    input  logic                 cfg_bidir,
    input  logic                 ld_start,
    input  logic                 ld_valid,
    input  logic [SP_WORD_W-1:0] ld_data,
    output logic [SP_WORD_W-1:0] tw_out,
    output logic [SP_ADDR_W-1:0] cur_addr
);

    sp_prof_t prof_q;
    logic     restart;
    sp_seg_t  wr_seg;
    sp_seg_t  sel_seg;
    sp_seg_t  act_cfg;
    logic     step;
    logic     ram_we;
    sp_addr_t ram_waddr;

    assign wr_seg  = sp_normalize(cfg_rate, cfg_first, cfg_last, sp_mode_e'(cfg_bidir));
    assign restart = upd || (prof_sel != prof_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prof_q  <= '0;
            act_cfg <= '0;
        end else if (restart) begin
            prof_q  <= prof_sel;
            act_cfg <= sel_seg;
        end
    end

    sp_cfg_bank #(.NPROF(SP_NPROF)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wr_slot (cfg_slot),
        .wr_seg  (wr_seg),
        .rd_slot (prof_sel),
        .rd_seg  (sel_seg)
    );

    sp_stepper u_step (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .start_addr (sel_seg.lo),
        .seg        (act_cfg),
        .addr       (cur_addr),
        .step       (step)
    );

    sp_loader u_load (
        .clk      (clk),
        .rst      (rst),
        .ld_start (ld_start),
        .ld_valid (ld_valid),
        .seg_lo   (act_cfg.lo),
        .seg_hi   (act_cfg.hi),
        .wr_en    (ram_we),
        .wr_addr  (ram_waddr)
    );

    sp_table_ram #(.AW(SP_ADDR_W), .DW(SP_WORD_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ld_data),
        .raddr (cur_addr),
        .rdata (tw_out)
    );

endmodule

// File: rtl/sp_checker.sv
module sp_checker
    import segplay_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     restart,
    input logic     step,
    input sp_addr_t cur_addr,
    input sp_addr_t seg_lo,
    input sp_addr_t seg_hi,
    input logic     seg_bidir,
    input logic     ram_we,
    input sp_addr_t ram_waddr
);

    assert_in_segment_R10: assert property (@(posedge clk) disable iff (rst)
        (cur_addr >= seg_lo) && (cur_addr <= seg_hi));

    assert_unit_move_R10: assert property (@(posedge clk) disable iff (rst)
        !restart |=> ((cur_addr == $past(cur_addr) + sp_addr_t'(1)) ||
                      (cur_addr == $past(cur_addr) - sp_addr_t'(1)) ||
                      $stable(cur_addr)));

    assert_restart_lo_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cur_addr == seg_lo));

    assert_dwell_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!restart && !step) |=> $stable(cur_addr));

    assert_oneshot_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!restart && !seg_bidir && (cur_addr == seg_hi)) |=> $stable(cur_addr));

    assert_load_in_segment_R3: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ((ram_waddr >= seg_lo) && (ram_waddr <= seg_hi)));

endmodule

bind segplay_top sp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .step      (step),
    .cur_addr  (cur_addr),
    .seg_lo    (act_cfg.lo),
    .seg_hi    (act_cfg.hi),
    .seg_bidir (act_cfg.mode == SP_BIDIR),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr)
);

// File: tb/sim_segplay_top.sv
module sim_segplay_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  prof_sel = '0;
    logic        upd = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic [15:0] cfg_rate = '0;
    logic [9:0]  cfg_first = '0;
    logic [9:0]  cfg_last = '0;
    logic        cfg_bidir = 1'b0;
    logic        ld_start = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] tw_out;
    logic [9:0]  cur_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] bmem [1024];
    logic [9:0]  q_addr [$];
    logic [31:0] q_word [$];
    string       q_tag  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    segplay_top u0 (
        .clk(clk), .rst(rst), .prof_sel(prof_sel), .upd(upd),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_rate(cfg_rate),
        .cfg_first(cfg_first), .cfg_last(cfg_last), .cfg_bidir(cfg_bidir),
        .ld_start(ld_start), .ld_valid(ld_valid), .ld_data(ld_data),
        .tw_out(tw_out), .cur_addr(cur_addr)
    );

    // Monitor: one scoreboard item per falling edge
    always @(negedge clk) begin : mon
        logic [9:0]  ea;
        logic [31:0] ew;
        string       et;
        if (q_addr.size() != 0) begin
            ea = q_addr.pop_front();
            ew = q_word.pop_front();
            et = q_tag.pop_front();
            checks++;
            if (cur_addr !== ea || tw_out !== ew) begin
                errors++;
                $display("FAIL %s: addr=%0d word=%h expected addr=%0d word=%h",
                         et, cur_addr, tw_out, ea, ew);
            end
        end
    end

    task automatic check_addr(input logic [9:0] exp, input string tag);
        checks++;
        if (cur_addr !== exp) begin
            errors++;
            $display("FAIL %s: addr=%0d expected addr=%0d", tag, cur_addr, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] slot, input logic [15:0] rate,
                             input logic [9:0] first, input logic [9:0] last,
                             input logic bidir);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = slot; cfg_rate = rate;
        cfg_first = first; cfg_last = last; cfg_bidir = bidir;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R3: pointer starts at upper address, walks down, wraps to upper
    task automatic load_words(input logic [9:0] lo, input logic [9:0] hi,
                              input logic [31:0] base, input int count);
        logic [9:0] p;
        p = hi;
        @(negedge clk);
        ld_start = 1'b1;
        @(negedge clk);
        ld_start = 1'b0;
        for (int k = 0; k < count; k++) begin
            ld_valid = 1'b1;
            ld_data  = base + 32'(k);
            bmem[p]  = base + 32'(k);
            p = (p == lo) ? hi : p - 10'd1;
            @(negedge clk);
        end
        ld_valid = 1'b0;
    endtask

    // Driver: cause a restart, then push the expected sweep from a model
    task automatic restart_play(input bit by_prof, input logic [1:0] newprof,
                                input logic [9:0] lo, input logic [9:0] hi,
                                input int rate, input bit bidir, input int n,
                                input string tag);
        int eff;
        int cnt;
        bit up;
        logic [9:0] a;
        @(negedge clk);
        if (by_prof) prof_sel = newprof;
        else upd = 1'b1;
        @(posedge clk);
        #1;
        eff = (rate == 0) ? 1 : rate;
        a = lo; cnt = 0; up = 1'b1;
        for (int i = 0; i < n; i++) begin
            q_addr.push_back(a);
            q_word.push_back(bmem[a]);
            q_tag.push_back(tag);
            cnt++;
            if (cnt == eff) begin
                cnt = 0;
                if (lo != hi) begin
                    if (!bidir) begin
                        if (a < hi) a = a + 10'd1;
                    end else if (up) begin
                        if (a < hi) a = a + 10'd1;
                        else begin a = a - 10'd1; up = 1'b0; end
                    end else begin
                        if (a > lo) a = a - 10'd1;
                        else begin a = a + 10'd1; up = 1'b1; end
                    end
                end
            end
        end
        @(negedge clk);
        upd = 1'b0;
        while (q_addr.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_addr(10'd0, "R1 reset state");
        end

        // Slot 0: rate 3, segment 0..7, up/down sweep
        write_cfg(2'd0, 16'd3, 10'd0, 10'd7, 1'b1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_addr(10'd0, "R2 no effect before restart");
        end
        restart_play(1'b0, 2'd0, 10'd0, 10'd7, 3, 1'b1, 0, "R6");
        // Nine words: the ninth wraps and overwrites address 7
        load_words(10'd0, 10'd7, 32'hC0DE_0000, 9);
        restart_play(1'b0, 2'd0, 10'd0, 10'd7, 3, 1'b1, 60, "R3/R4/R5/R7/R10");

        // Slot 1: rate 0, first 12 last 10 (swapped), single climb
        write_cfg(2'd1, 16'd0, 10'd12, 10'd10, 1'b0);
        restart_play(1'b1, 2'd1, 10'd10, 10'd12, 0, 1'b0, 1, "R6/R9");
        load_words(10'd10, 10'd12, 32'hA5A5_0000, 3);
        restart_play(1'b0, 2'd1, 10'd10, 10'd12, 0, 1'b0, 8, "R5/R8/R9");

        // Slot 3: rate 5, 4..6 single climb, profile pin change
        write_cfg(2'd3, 16'd5, 10'd4, 10'd6, 1'b0);
        restart_play(1'b1, 2'd3, 10'd4, 10'd6, 5, 1'b0, 25, "R4/R6/R8/R10");

        // Rewrite the active slot without a restart: playback unchanged
        write_cfg(2'd3, 16'd1, 10'd0, 10'd7, 1'b1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_addr(10'd6, "R2 active slot rewrite ignored");
        end

        // Slot 0 rewritten with swapped ends, reselected by pin change
        write_cfg(2'd0, 16'd2, 10'd3, 10'd1, 1'b1);
        restart_play(1'b1, 2'd0, 10'd1, 10'd3, 2, 1'b1, 20, "R2/R6/R7/R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule